// File: doc/BRIEF.md
# Message-Signalled Interrupt Request Generator

This block sits between application logic and a PCIe transaction layer. Application logic raises interrupt events as single-cycle pulses on a 32-bit event bus, one bit per vector index. The block records each event in a pending vector. It then presents the pending events one at a time as requests on a request/acknowledge handshake toward the transaction layer. Each request carries a 3-bit traffic class and a 5-bit vector number.

Host software may grant fewer vectors than the device asked for. The block therefore reads the granted count from the 16-bit MSI control word. Bit 0 of that word is the global enable. Bits [6:4] hold a field value k that grants 2^k vectors. The block keeps the low k bits of the chosen index and forces the upper bits to zero, so the requested vector number always lies inside the granted range.

Top module: `msi_req_gen`

## Requirements
- R1: After reset, `msi_req_o`, `msi_tc_o` and `msi_num_o` are all zero and no event is pending; no request appears until a new event arrives.
- R2: Once `msi_req_o` is high, it stays high with `msi_tc_o` (3 bits) and `msi_num_o` (5 bits) unchanged until the first cycle in which `msi_ack_i` is high.
- R3: An edge with `msi_req_o` and `msi_ack_i` both high drops `msi_req_o` at that edge and clears the pending bit of the served index. If other events are pending, the next request rises at the following edge.
- R4: When several events are pending, the lowest index is served first.
- R5: With k = `msi_ctrl_i[6:4]`, the vector number is the chosen index ANDed with 2^k-1. Values 6 and 7 behave as 5, which grants all 32 vectors.
- R6: While `msi_ctrl_i[0]` is 0, no new request starts. Events stay pending and are issued once the bit is set.
- R7: An event at an index that is already pending, including the one in flight before its acknowledge, merges into the one request. An event at the served index in the acknowledge cycle stays pending and is requested again.
- R8: `msi_tc_o` is the value of `tc_i` at the edge where the request starts.
- R9: Changes of `msi_ctrl_i` while a request is outstanding do not change `msi_num_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 32 | Event pulses, one bit per vector index |
| tc_i | input | 3 | Traffic class taken at request start |
| msi_ctrl_i | input | 16 | MSI control word: bit 0 enable, bits [6:4] granted vector field |
| msi_ack_i | input | 1 | Acknowledge from the transaction layer |
| msi_req_o | output | 1 | Request, held until acknowledged |
| msi_tc_o | output | 3 | Traffic class of the request |
| msi_num_o | output | 5 | Clamped vector number of the request |

## Verification
The assertions check on every cycle that an outstanding request holds its class and number until acknowledged (R2). They also check that a request falls right after its acknowledge (R3), that it only starts while enabled with something pending (R6), and that its number fits the granted field at start (R5). Event capture and the clearing of the pending bit are checked in the queue (R7). Only the directed scenarios can show the serving order across several pending events (R4) and the exact masked numbers for each field value. The same holds for events held back by the enable bit and for merging versus re-request at the acknowledge edge.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned CTRL_W     = 16;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned GRANT_LSB  = 4;
  localparam int unsigned GRANT_W    = 3;
endpackage

// File: rtl/msi_pend_queue.sv
module msi_pend_queue #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned NUM_W  = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic               clr_en_i,
  input  logic [NUM_W-1:0]   clr_idx_i,
  output logic               pend_any_o,
  output logic [NUM_W-1:0]   pick_idx_o
);
  logic [NUM_VEC-1:0] pend_q, clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en_i) clr_mask[clr_idx_i] = 1'b1;
  end

  // event in the clear cycle wins, so it is re-requested
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | evt_i;
  end

  always_comb begin
    pick_idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (pend_q[i]) pick_idx_o = NUM_W'(i);
  end

  assign pend_any_o = |pend_q;

  assert_evt_captured_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_on_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !evt_i[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/msi_vec_clamp.sv
module msi_vec_clamp #(
  parameter int unsigned NUM_VEC = 32,
  localparam int unsigned NUM_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_W-1:0] idx_i,
  input  logic [2:0]       grant_i,
  output logic [2:0]       k_eff_o,
  output logic [NUM_W-1:0] num_o
);
  logic [NUM_W-1:0] mask;

  // field values above the index width grant every vector
  assign k_eff_o = (grant_i > 3'(NUM_W)) ? 3'(NUM_W) : grant_i;

  always_comb begin
    for (int i = 0; i < NUM_W; i++) mask[i] = (i < int'(k_eff_o));
  end

  assign num_o = idx_i & mask;
endmodule

// File: rtl/msi_handshake.sv
module msi_handshake #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned TC_W    = 3,
  localparam int unsigned NUM_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_ok_i,
  input  logic [NUM_W-1:0] idx_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [TC_W-1:0]  tc_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [TC_W-1:0]  tc_o,
  output logic [NUM_W-1:0] num_o,
  output logic [NUM_W-1:0] idx_o,
  output logic             done_o
);
  assign done_o = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      tc_o  <= '0;
      num_o <= '0;
      idx_o <= '0;
    end else if (!req_o) begin
      if (launch_ok_i) begin
        req_o <= 1'b1;
        tc_o  <= tc_i;
        num_o <= num_i;
        idx_o <= idx_i;
      end
    end else if (ack_i) begin
      req_o <= 1'b0;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(tc_o) && $stable(num_o)));

  assert_req_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);

  assert_start_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(launch_ok_i));
endmodule

// File: rtl/msi_req_gen.sv
module msi_req_gen
  import msi_pkg::*;
#(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned TC_W    = 3,
  localparam int unsigned NUM_W  = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] event_i,
  input  logic [TC_W-1:0]    tc_i,
  input  logic [CTRL_W-1:0]  msi_ctrl_i,
  input  logic               msi_ack_i,
  output logic               msi_req_o,
  output logic [TC_W-1:0]    msi_tc_o,
  output logic [NUM_W-1:0]   msi_num_o
);
  logic               msi_en, pend_any, done;
  logic [NUM_W-1:0]   pick_idx, pick_num, cur_idx;
  logic [GRANT_W-1:0] k_eff;
  logic               unused_ctrl;

  assign msi_en      = msi_ctrl_i[EN_BIT];
  assign unused_ctrl = ^{msi_ctrl_i[CTRL_W-1:GRANT_LSB+GRANT_W], msi_ctrl_i[GRANT_LSB-1:EN_BIT+1]};

  msi_pend_queue #(.NUM_VEC(NUM_VEC)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (event_i),
    .clr_en_i   (done),
    .clr_idx_i  (cur_idx),
    .pend_any_o (pend_any),
    .pick_idx_o (pick_idx)
  );

  msi_vec_clamp #(.NUM_VEC(NUM_VEC)) u_clamp (
    .idx_i   (pick_idx),
    .grant_i (msi_ctrl_i[GRANT_LSB +: GRANT_W]),
    .k_eff_o (k_eff),
    .num_o   (pick_num)
  );

  msi_handshake #(.NUM_VEC(NUM_VEC), .TC_W(TC_W)) u_hs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_ok_i (msi_en && pend_any),
    .idx_i       (pick_idx),
    .num_i       (pick_num),
    .tc_i        (tc_i),
    .ack_i       (msi_ack_i),
    .req_o       (msi_req_o),
    .tc_o        (msi_tc_o),
    .num_o       (msi_num_o),
    .idx_o       (cur_idx),
    .done_o      (done)
  );

  assert_num_in_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_req_o) |-> ((msi_num_o >> $past(k_eff)) == '0));

  assert_start_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_req_o) |-> $past(msi_en));
endmodule

// File: tb/msi_req_gen_tb.sv
module msi_req_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] event_i = '0;
  logic [2:0]  tc_i = '0;
  logic [15:0] ctrl = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [2:0]  tc_o;
  logic [4:0]  num_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msi_req_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_i), .tc_i(tc_i),
    .msi_ctrl_i(ctrl), .msi_ack_i(ack), .msi_req_o(req),
    .msi_tc_o(tc_o), .msi_num_o(num_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit en, input int k);
    return {9'b0, 3'(k), 3'b0, en};
  endfunction

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); event_i = m;
    @(negedge clk); event_i = '0;
  endtask

  task automatic wait_req(input string tag, input int exp_num, input int exp_tc);
    int n = 0;
    while (!req && n < 20) begin @(negedge clk); n++; end
    chk(req == 1'b1, {tag, " req"}, int'(req), 1);
    chk(num_o == 5'(exp_num), {tag, " num"}, int'(num_o), exp_num);
    chk(tc_o == 3'(exp_tc), {tag, " tc"}, int'(tc_o), exp_tc);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk(req == 1'b0, "R3 req drops after ack", int'(req), 0);
  endtask

  task automatic t_reset();
    chk(req == 1'b0 && tc_o == 3'd0 && num_o == 5'd0, "R1 reset outputs", int'({req, tc_o, num_o}), 0);
    ctrl = mk_ctrl(1, 5);
    repeat (4) @(negedge clk);
    chk(req == 1'b0, "R1 nothing pending after reset", int'(req), 0);
  endtask

  task automatic t_basic();
    tc_i = 3'd3;
    pulse(32'h1 << 7);
    wait_req("R2 basic", 7, 3);
    tc_i = 3'd6; ctrl = mk_ctrl(1, 1);
    repeat (5) @(negedge clk);
    chk(req == 1'b1 && num_o == 5'd7, "R2 R9 held num", int'(num_o), 7);
    chk(tc_o == 3'd3, "R8 tc held", int'(tc_o), 3);
    do_ack();
    ctrl = mk_ctrl(1, 5);
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R3 pending cleared", int'(req), 0);
  endtask

  task automatic t_priority();
    tc_i = 3'd1;
    pulse((32'h1 << 20) | (32'h1 << 3) | (32'h1 << 9));
    wait_req("R4 first", 3, 1);
    do_ack();
    @(negedge clk);
    chk(req == 1'b1 && num_o == 5'd9, "R4 R3 second next cycle", int'(num_o), 9);
    do_ack();
    @(negedge clk);
    chk(req == 1'b1 && num_o == 5'd20, "R4 third", int'(num_o), 20);
    do_ack();
    repeat (2) @(negedge clk);
    chk(req == 1'b0, "R4 queue empty", int'(req), 0);
  endtask

  task automatic clamp_one(input int k, input int idx, input int exp);
    ctrl = mk_ctrl(1, k);
    pulse(32'h1 << idx);
    wait_req("R5 clamp", exp, 1);
    do_ack();
    @(negedge clk);
  endtask

  task automatic t_clamp();
    clamp_one(1, 6, 0);
    clamp_one(1, 7, 1);
    clamp_one(3, 13, 5);
    clamp_one(0, 9, 0);
    clamp_one(7, 29, 29);
    clamp_one(4, 31, 15);
  endtask

  task automatic t_enable();
    ctrl = mk_ctrl(0, 5);
    pulse(32'h1 << 4);
    repeat (5) @(negedge clk);
    chk(req == 1'b0, "R6 disabled no request", int'(req), 0);
    ctrl = mk_ctrl(1, 5);
    wait_req("R6 after enable", 4, 1);
    do_ack();
    @(negedge clk);
  endtask

  task automatic t_merge();
    ctrl = mk_ctrl(0, 5);
    pulse(32'h1 << 2);
    pulse(32'h1 << 2);
    ctrl = mk_ctrl(1, 5);
    wait_req("R7 merged", 2, 1);
    pulse(32'h1 << 2);
    do_ack();
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R7 single request for merged", int'(req), 0);
    pulse(32'h1 << 5);
    wait_req("R7 in flight", 5, 1);
    ack = 1'b1; event_i = 32'h1 << 5;
    @(negedge clk); ack = 1'b0; event_i = '0;
    chk(req == 1'b0, "R7 drop at ack", int'(req), 0);
    @(negedge clk);
    chk(req == 1'b1 && num_o == 5'd5, "R7 re-request", int'(num_o), 5);
    do_ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_clamp();
    t_enable();
    t_merge();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule